// File: doc/BRIEF.md
# Loop Address Hardware Stack

This block is a small last-in-first-out store of loop context. It lets hardware loops nest. Each entry holds the address of a loop's first instruction and a loop flag bit. When a loop starts, the loop sequencer pushes an entry. When the loop ends, the sequencer pops it. The innermost loop's context is always on top, so the enclosing loop can resume from the entry beneath it once the inner loop finishes. The top entry is shown combinationally on the outputs at all times, together with a valid flag and the current depth.

Software reaches the same store through a register-style port. A write pushes a 24-bit entry and a read pops the top. The value read is the top entry shown on `top_o` in the cycle of the read. The store is two entries deep. A push into a full stack throws away the oldest entry, keeps the two newest, and raises a one-cycle non-maskable overflow request. A pop from an empty stack is harmless and raises no request.

Top module: `loop_hw_stack`

## Requirements
- R1: After reset the stack is empty: `valid_o`=0, `depth_o`=0, `top_o`=0 and `ovf_irq_o`=0.
- R2: An entry is 24 bits. The address sits in bits 20:0 and the loop flag in bit 23. Bits 22:21 always read as zero, including after a software write that sets them.
- R3: Entries leave in reverse order of arrival. After a pop, the entry pushed before the popped one is on `top_o` in the next cycle.
- R4: `depth_o` counts the stored entries. It never exceeds 2, and `valid_o` is 1 exactly when `depth_o` is non-zero.
- R5: A push into a full stack discards the oldest entry. Depth stays 2, the new entry is on top and the previous top sits beneath it.
- R6: A push into a full stack sets `ovf_irq_o` high for exactly the one cycle after the push edge. No other operation sets it.
- R7: A pop from an empty stack leaves the stack empty, keeps `top_o` at zero and does not raise `ovf_irq_o`.
- R8: A push and a pop in the same cycle on a non-empty stack replace the top entry and leave the depth unchanged, with no overflow. On an empty stack the pair acts as a plain push.
- R9: `sw_push_i` pushes `sw_wdata_i` and `sw_pop_i` pops. Loop and software requests combine into one operation. When both ports push in the same cycle, only the loop-port entry is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_push_i | input | 1 | Loop start: push loop context |
| loop_addr_i | input | 21 | Top-of-loop address to push |
| loop_lf_i | input | 1 | Loop flag to push |
| loop_pop_i | input | 1 | Loop end: pop top entry |
| sw_push_i | input | 1 | Software write: push `sw_wdata_i` |
| sw_wdata_i | input | 24 | Software entry to push |
| sw_pop_i | input | 1 | Software read: pop top entry |
| top_o | output | 24 | Top entry, zero when empty |
| top_addr_o | output | 21 | Address field of top entry |
| top_lf_o | output | 1 | Loop flag of top entry |
| valid_o | output | 1 | Stack holds at least one entry |
| depth_o | output | 2 | Number of stored entries |
| ovf_irq_o | output | 1 | One-cycle non-maskable overflow request |

## Verification
A wrong depth counter shows up on `valid_o`, `depth_o` and `top_o` in the cycle right after the faulty edge. The bench compares all three after every operation, so such an error is caught at once. A fault in the overflow shift leaves the wrong entry stored beneath the top. That entry only reaches the ports when it is popped, so each overflow case is followed by pops that uncover the whole stored order. Overflow signalling is checked in the cycle after the push and again in the next cycle, to catch a pulse that is held too long.

// File: rtl/lstk_pkg.sv
package lstk_pkg;
   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_PUSH = 2'd1,
      OP_POP  = 2'd2,
      OP_SWAP = 2'd3
   } lstk_op_e;
endpackage

// File: rtl/lstk_ctrl.sv
module lstk_ctrl #(
   parameter int ADDR_W  = 21,
   parameter int ENTRY_W = 24,
   parameter int LF_BIT  = 23
) (
   input  logic                 loop_push_i,
   input  logic [ADDR_W-1:0]    loop_addr_i,
   input  logic                 loop_lf_i,
   input  logic                 loop_pop_i,
   input  logic                 sw_push_i,
   input  logic [ENTRY_W-1:0]   sw_wdata_i,
   input  logic                 sw_pop_i,
   input  logic                 empty_i,
   output lstk_pkg::lstk_op_e   op_o,
   output logic [ENTRY_W-1:0]   wdata_o
);
   import lstk_pkg::*;

   localparam logic [ENTRY_W-1:0] KEEP_MASK =
      {{(ENTRY_W-ADDR_W){1'b0}}, {ADDR_W{1'b1}}} | (ENTRY_W'(1) << LF_BIT);

   logic push_req, pop_req;
   logic [ENTRY_W-1:0] loop_entry;

   assign push_req = loop_push_i | sw_push_i;
   assign pop_req  = loop_pop_i  | sw_pop_i;

   always_comb begin
      loop_entry = '0;
      loop_entry[ADDR_W-1:0] = loop_addr_i;
      loop_entry[LF_BIT]     = loop_lf_i;
   end

   assign wdata_o = loop_push_i ? loop_entry : (sw_wdata_i & KEEP_MASK);

   always_comb begin
      unique case ({push_req, pop_req})
         2'b10:   op_o = OP_PUSH;
         2'b01:   op_o = empty_i ? OP_IDLE : OP_POP;
         2'b11:   op_o = empty_i ? OP_PUSH : OP_SWAP;
         default: op_o = OP_IDLE;
      endcase
   end
endmodule

// File: rtl/lstk_store.sv
module lstk_store #(
   parameter int ENTRY_W = 24,
   parameter int DEPTH   = 2,
   parameter int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  lstk_pkg::lstk_op_e   op_i,
   input  logic [ENTRY_W-1:0]   wdata_i,
   output logic [ENTRY_W-1:0]   top_o,
   output logic [CNT_W-1:0]     cnt_o,
   output logic                 ovf_o
);
   import lstk_pkg::*;

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   logic [ENTRY_W-1:0] mem [DEPTH];
   logic [CNT_W-1:0]   cnt_q;
   logic               full;
   logic               ovf_q;

   assign full = (cnt_q == FULL_CNT);

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [ENTRY_W-1:0] q;
      logic [ENTRY_W-1:0] shift_in;
      if (i == DEPTH - 1) begin : g_top
         assign shift_in = wdata_i;
      end else begin : g_mid
         assign shift_in = mem[i+1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else begin
            unique case (op_i)
               OP_PUSH: begin
                  if (full)                  q <= shift_in;
                  else if (cnt_q == CNT_W'(i)) q <= wdata_i;
               end
               OP_SWAP: if (cnt_q == CNT_W'(i + 1)) q <= wdata_i;
               OP_POP:  if (cnt_q == CNT_W'(i + 1)) q <= '0;
               default: ;
            endcase
         end
      end
      assign mem[i] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         ovf_q <= (op_i == OP_PUSH) && full;
         if (op_i == OP_PUSH && !full)             cnt_q <= cnt_q + 1'b1;
         else if (op_i == OP_POP && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      end
   end

   always_comb begin
      top_o = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (cnt_q == CNT_W'(k + 1)) top_o = mem[k];
      end
   end

   assign cnt_o = cnt_q;
   assign ovf_o = ovf_q;

   // R4
   depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL_CNT);

   // R6
   ovf_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_PUSH && full) |=> ovf_o);

   // R6
   ovf_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i != OP_PUSH) |=> !ovf_o);

   // R8
   swap_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_SWAP) |=> ($stable(cnt_o) && !ovf_o));
endmodule

// File: rtl/loop_hw_stack.sv
module loop_hw_stack #(
   parameter int ADDR_W  = 21,
   parameter int ENTRY_W = 24,
   parameter int LF_BIT  = 23,
   parameter int DEPTH   = 2,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               loop_push_i,
   input  logic [ADDR_W-1:0]  loop_addr_i,
   input  logic               loop_lf_i,
   input  logic               loop_pop_i,
   input  logic               sw_push_i,
   input  logic [ENTRY_W-1:0] sw_wdata_i,
   input  logic               sw_pop_i,
   output logic [ENTRY_W-1:0] top_o,
   output logic [ADDR_W-1:0]  top_addr_o,
   output logic               top_lf_o,
   output logic               valid_o,
   output logic [CNT_W-1:0]   depth_o,
   output logic               ovf_irq_o
);
   import lstk_pkg::*;

   if (DEPTH < 1) begin : g_bad_depth
      $error("loop_hw_stack: DEPTH must be at least 1");
   end
   if (LF_BIT <= ADDR_W || LF_BIT >= ENTRY_W) begin : g_bad_lf
      $error("loop_hw_stack: LF_BIT must lie above the address field and inside the entry");
   end

   lstk_op_e           op;
   logic [ENTRY_W-1:0] wdata;

   lstk_ctrl #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W), .LF_BIT(LF_BIT)) u_ctrl (
      .loop_push_i (loop_push_i),
      .loop_addr_i (loop_addr_i),
      .loop_lf_i   (loop_lf_i),
      .loop_pop_i  (loop_pop_i),
      .sw_push_i   (sw_push_i),
      .sw_wdata_i  (sw_wdata_i),
      .sw_pop_i    (sw_pop_i),
      .empty_i     (depth_o == '0),
      .op_o        (op),
      .wdata_o     (wdata)
   );

   lstk_store #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_i    (op),
      .wdata_i (wdata),
      .top_o   (top_o),
      .cnt_o   (depth_o),
      .ovf_o   (ovf_irq_o)
   );

   assign top_addr_o = top_o[ADDR_W-1:0];
   assign top_lf_o   = top_o[LF_BIT];
   assign valid_o    = (depth_o != '0);

   // R2
   spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      top_o[LF_BIT-1:ADDR_W] == '0);

   // R7
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((loop_pop_i || sw_pop_i) && !loop_push_i && !sw_push_i && depth_o == '0)
      |=> (depth_o == '0 && top_o == '0 && !ovf_irq_o));

   // R1
   empty_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (depth_o == '0) |-> (top_o == '0));
endmodule

// File: tb/loop_hw_stack_tb.sv
module loop_hw_stack_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        loop_push_i = 0, loop_lf_i = 0, loop_pop_i = 0;
   logic [20:0] loop_addr_i = '0;
   logic        sw_push_i = 0, sw_pop_i = 0;
   logic [23:0] sw_wdata_i = '0;
   logic [23:0] top_o;
   logic [20:0] top_addr_o;
   logic        top_lf_o, valid_o, ovf_irq_o;
   logic [1:0]  depth_o;

   int checks = 0;
   int fails  = 0;

   typedef struct {
      logic [23:0] top;
      int          depth;
      logic        ovf;
      string       tag;
   } exp_t;

   exp_t        exp_q[$];
   logic [23:0] model[$];

   always #5 clk = ~clk;

   loop_hw_stack u_dut (
      .clk(clk), .rst_n(rst_n),
      .loop_push_i(loop_push_i), .loop_addr_i(loop_addr_i), .loop_lf_i(loop_lf_i),
      .loop_pop_i(loop_pop_i), .sw_push_i(sw_push_i), .sw_wdata_i(sw_wdata_i),
      .sw_pop_i(sw_pop_i), .top_o(top_o), .top_addr_o(top_addr_o), .top_lf_o(top_lf_o),
      .valid_o(valid_o), .depth_o(depth_o), .ovf_irq_o(ovf_irq_o)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   // Driver: applies one operation, advances the model and queues the expected view.
   task automatic step(input bit lp, input logic [20:0] la, input bit ll, input bit lpop,
                       input bit sp, input logic [23:0] sd, input bit spop, input string tag);
      logic [23:0] d;
      bit push, pop, ovf;
      exp_t e;
      @(negedge clk);
      loop_push_i = lp; loop_addr_i = la; loop_lf_i = ll; loop_pop_i = lpop;
      sw_push_i = sp; sw_wdata_i = sd; sw_pop_i = spop;
      @(posedge clk);
      #1;
      d    = lp ? {ll, 2'b00, la} : {sd[23], 2'b00, sd[20:0]};
      push = lp | sp;
      pop  = lpop | spop;
      ovf  = 0;
      if (push && pop && model.size() != 0) begin
         model[model.size()-1] = d;
      end else if (push) begin
         if (model.size() == 2) begin
            void'(model.pop_front());
            ovf = 1;
         end
         model.push_back(d);
      end else if (pop && model.size() != 0) begin
         void'(model.pop_back());
      end
      e.top   = (model.size() != 0) ? model[model.size()-1] : 24'h0;
      e.depth = model.size();
      e.ovf   = ovf;
      e.tag   = tag;
      exp_q.push_back(e);
   endtask

   // Monitor: compares queued expectations after each edge.
   always @(posedge clk) begin
      #3;
      while (exp_q.size() != 0) begin
         exp_t e;
         e = exp_q.pop_front();
         chk(e.tag, "top", 32'(top_o), 32'(e.top));
         chk(e.tag, "addr", 32'(top_addr_o), 32'(e.top[20:0]));
         chk(e.tag, "lf", 32'(top_lf_o), 32'(e.top[23]));
         chk(e.tag, "depth", 32'(depth_o), 32'(e.depth));
         chk(e.tag, "valid", 32'(valid_o), 32'(e.depth != 0));
         chk(e.tag, "ovf", 32'(ovf_irq_o), 32'(e.ovf));
      end
   end

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1", "valid", 32'(valid_o), 0);
      chk("R1", "depth", 32'(depth_o), 0);
      chk("R1", "top", 32'(top_o), 0);
      chk("R1", "ovf", 32'(ovf_irq_o), 0);
      rst_n = 1'b1;

      // R2/R3/R4: nest two loops then unwind
      step(1, 21'h1ABCDE, 1, 0, 0, '0, 0, "R2");
      step(1, 21'h000123, 0, 0, 0, '0, 0, "R4");
      step(0, '0, 0, 1, 0, '0, 0, "R3");
      step(0, '0, 0, 1, 0, '0, 0, "R3");
      // R7: pop on empty, twice
      step(0, '0, 0, 1, 0, '0, 0, "R7");
      step(0, '0, 0, 0, 0, '0, 1, "R7");
      // R5/R6: overflow drops oldest
      step(1, 21'h00AAAA, 1, 0, 0, '0, 0, "R5");
      step(1, 21'h00BBBB, 0, 0, 0, '0, 0, "R5");
      step(1, 21'h00CCCC, 1, 0, 0, '0, 0, "R6");
      step(0, '0, 0, 0, 0, '0, 0, "R6");
      step(0, '0, 0, 1, 0, '0, 0, "R5");
      step(0, '0, 0, 1, 0, '0, 0, "R5");
      // R8: push+pop on empty then on non-empty, then with full stack
      step(1, 21'h011111, 0, 1, 0, '0, 0, "R8");
      step(1, 21'h022222, 1, 1, 0, '0, 0, "R8");
      step(1, 21'h033333, 0, 0, 0, '0, 0, "R8");
      step(1, 21'h044444, 1, 1, 0, '0, 0, "R8");
      step(0, '0, 0, 1, 0, '0, 0, "R8");
      // R9/R2: software write with spare bits set, overflow through software
      step(0, '0, 0, 0, 1, 24'hFFFFFF, 0, "R9");
      step(0, '0, 0, 0, 1, 24'h612345, 0, "R9");
      step(0, '0, 0, 0, 0, '0, 1, "R9");
      step(0, '0, 0, 0, 0, '0, 1, "R9");
      step(0, '0, 0, 0, 0, '0, 1, "R9");
      // R9: both ports push in one cycle, loop data stored
      step(1, 21'h155555, 1, 0, 1, 24'h0ABCDE, 0, "R9");
      step(0, '0, 0, 0, 0, '0, 1, "R9");
      step(0, '0, 0, 0, 0, '0, 0, "R4");

      repeat (3) @(posedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule